// File: doc/BRIEF.md
# Subroutine Return and Return-Address Stack

This block is one execution slice of a small 8-bit controller that uses 14-bit instruction words. It owns the program counter and a circular hardware stack of return addresses. From the instruction stream it handles four opcodes: an idle opcode and three kinds of return. Every return pops the most recent return address into the program counter. One of them also sets the global interrupt enable flag. Another also loads an 8-bit constant into the W accumulator. A run of these literal-returning entries is how constant tables are built. A computed jump lands on one entry, and that entry returns its own value in W.

A separate call unit pushes return addresses through a push request port. Every return occupies two cycles. In the second cycle the block raises `busy` and discards whatever instruction word is presented, which flushes the word fetched behind the return. An opcode this block does not recognise leaves all of its state alone. The block reports such an opcode on a one-cycle flag so that other execution units can claim it.

Top module: `retstk_unit`

## Requirements
- R1: While synchronous reset `rst` is high and on the first cycle after it, `pc_q`, `w_q`, `gie_q`, `busy` and `unhandled` are 0, and the stack is empty (stack pointer 0).
- R2: An accepted word 14'h0000 (idle) changes none of PC, W, GIE, or the stack, and does not raise `busy`.
- R3: An accepted word 14'h0040 (plain return) pops the stack. After the accepting edge, `pc_q` holds the popped address and `busy` is high for exactly one cycle.
- R4: An accepted word 14'h0060 (interrupt return) pops into `pc_q` like R3 and sets `gie_q` to 1 at the same edge.
- R5: An accepted word whose bits [13:8] are 6'b011000 (literal return) loads bits [7:0] into `w_q` and pops into `pc_q` at the same edge, for every literal from 8'h00 to 8'hFF.
- R6: A word is accepted only when `instr_valid` is high and `busy` is low. The word presented during the busy cycle has no effect on PC, W, GIE, the stack or `unhandled`.
- R7: Any other accepted word leaves PC, W, GIE and the stack unchanged. It drives `unhandled` high for the one cycle after the accepting edge.
- R8: A `push_req` writes `push_addr` onto the stack. Pops return the pushed addresses in last-in, first-out order.
- R9: The stack has 8 entries and wraps. The ninth push overwrites the oldest entry. A pop from an empty stack returns the slot reached by wrapping the pointer down, and no error is flagged.
- R10: A `push_req` in the same cycle as an accepted return is dropped.
- R11: No instruction clears `gie_q`. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 14 | Fetched instruction word |
| push_req | input | 1 | Push a return address (call) |
| push_addr | input | PC_W (10) | Return address to push |
| pc_q | output | PC_W (10) | Program counter |
| w_q | output | 8 | W accumulator |
| gie_q | output | 1 | Global interrupt enable |
| busy | output | 1 | Second cycle of a return; input word ignored |
| unhandled | output | 1 | Previous accepted word was not handled here |

## Verification
The bench works through the cases around the flush cycle. If a design acted on the word presented while `busy` is high, it would pop twice or flag a spurious unhandled opcode. Near-miss opcodes such as 14'h0041 and 14'h1900 are included, because a decoder that masks too many bits would treat them as returns and move the PC. The bench also pushes nine addresses and pops ten to check the wrap on overflow and on underflow. A design that saturated its pointer would return the wrong address there. A push that coincides with a return is also exercised: a design that honoured it would corrupt the later pop order.

// File: rtl/retstk_pkg.sv
package retstk_pkg;
  typedef enum logic [2:0] {
    OPK_NONE,
    OPK_IDLE,
    OPK_RET,
    OPK_RETI,
    OPK_RETLW,
    OPK_OTHER
  } opkind_t;

  localparam int unsigned IW = 14;
  localparam int unsigned DW = 8;

  localparam logic [IW-1:0] ENC_IDLE = 14'h0000;
  localparam logic [IW-1:0] ENC_RET  = 14'h0040;
  localparam logic [IW-1:0] ENC_RETI = 14'h0060;
  localparam logic [5:0]    ENC_RETLW_HI = 6'b011000;
endpackage

// File: rtl/retstk_decode.sv
module retstk_decode
  import retstk_pkg::*;
(
  input  logic          instr_valid,
  input  logic [IW-1:0] instr_word,
  input  logic          busy,
  output opkind_t       kind,
  output logic          is_return,
  output logic [DW-1:0] literal
);
  logic accept;

  assign accept  = instr_valid && !busy;
  assign literal = instr_word[DW-1:0];

  always_comb begin
    if (!accept)                                   kind = OPK_NONE;
    else if (instr_word == ENC_IDLE)               kind = OPK_IDLE;
    else if (instr_word == ENC_RET)                kind = OPK_RET;
    else if (instr_word == ENC_RETI)               kind = OPK_RETI;
    else if (instr_word[IW-1:DW] == ENC_RETLW_HI)  kind = OPK_RETLW;
    else                                           kind = OPK_OTHER;
  end

  assign is_return = (kind == OPK_RET) || (kind == OPK_RETI) || (kind == OPK_RETLW);
endmodule

// File: rtl/retstk_lifo.sv
module retstk_lifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic [AW-1:0] push_data,
  input  logic          pop_en,
  output logic [AW-1:0] top_data
);
  localparam int unsigned SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_dn;

  assign sp_dn    = (sp == '0) ? SPW'(DEPTH - 1) : sp - SPW'(1);
  assign top_data = mem[sp_dn];

  always_ff @(posedge clk) begin
    if (push_en) mem[sp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push_en) begin
      sp <= (sp == SPW'(DEPTH - 1)) ? '0 : sp + SPW'(1);
    end else if (pop_en) begin
      sp <= sp_dn;
    end
  end

  // R10
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(push_en && pop_en));
endmodule

// File: rtl/retstk_state.sv
module retstk_state
  import retstk_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  opkind_t       kind,
  input  logic          is_return,
  input  logic [DW-1:0] literal,
  input  logic [AW-1:0] pop_addr,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] w_q,
  output logic          gie_q,
  output logic          busy,
  output logic          unhandled
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      w_q       <= '0;
      gie_q     <= 1'b0;
      busy      <= 1'b0;
      unhandled <= 1'b0;
    end else begin
      busy      <= is_return;
      unhandled <= (kind == OPK_OTHER);
      if (is_return) pc_q <= pop_addr;
      if (kind == OPK_RETI) gie_q <= 1'b1;
      if (kind == OPK_RETLW) w_q <= literal;
    end
  end

  // R3
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
  // R11
  gie_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    gie_q |=> gie_q);
  // R6
  w_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(w_q));
  // R6
  no_unh_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !unhandled);
  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !is_return |=> $stable(pc_q));
endmodule

// File: rtl/retstk_unit.sv
module retstk_unit
  import retstk_pkg::*;
#(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [13:0]     instr_word,
  input  logic            push_req,
  input  logic [PC_W-1:0] push_addr,
  output logic [PC_W-1:0] pc_q,
  output logic [7:0]      w_q,
  output logic            gie_q,
  output logic            busy,
  output logic            unhandled
);
  opkind_t         kind;
  logic            is_return;
  logic [DW-1:0]   literal;
  logic [PC_W-1:0] pop_addr;
  logic            push_en;

  assign push_en = push_req && !is_return;

  retstk_decode u_dec (
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .busy        (busy),
    .kind        (kind),
    .is_return   (is_return),
    .literal     (literal)
  );

  retstk_lifo #(.DEPTH(DEPTH), .AW(PC_W)) u_lifo (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push_en),
    .push_data (push_addr),
    .pop_en    (is_return),
    .top_data  (pop_addr)
  );

  retstk_state #(.AW(PC_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .is_return (is_return),
    .literal   (literal),
    .pop_addr  (pop_addr),
    .pc_q      (pc_q),
    .w_q       (w_q),
    .gie_q     (gie_q),
    .busy      (busy),
    .unhandled (unhandled)
  );

  // R2
  idle_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == OPK_IDLE) |=> (!busy && $stable(pc_q) && $stable(gie_q)));
endmodule

// File: tb/retstk_unit_tb.sv
module retstk_unit_tb_top;
  localparam int PCW = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           instr_valid = 1'b0;
  logic [13:0]    instr_word = '0;
  logic           push_req = 1'b0;
  logic [PCW-1:0] push_addr = '0;
  logic [PCW-1:0] pc_q;
  logic [7:0]     w_q;
  logic           gie_q, busy, unhandled;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_stk [8];
  int m_sp = 0;
  int m_pc = 0, m_w = 0, m_gie = 0, m_busy = 0, m_unh = 0;

  always #2.5 clk = ~clk;

  retstk_unit dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .push_req(push_req), .push_addr(push_addr), .pc_q(pc_q), .w_q(w_q),
    .gie_q(gie_q), .busy(busy), .unhandled(unhandled)
  );

  task automatic cmp(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    cmp(tag, int'(pc_q), m_pc, "pc");
    cmp(tag, int'(w_q), m_w, "w");
    cmp(tag, int'(gie_q), m_gie, "gie");
    cmp(tag, int'(busy), m_busy, "busy");
    cmp(tag, int'(unhandled), m_unh, "unhandled");
  endtask

  task automatic step(input string tag, input bit v, input logic [13:0] wd,
                      input bit p, input int pa);
    bit acc, ret;
    @(negedge clk);
    instr_valid = v; instr_word = wd; push_req = p; push_addr = PCW'(pa);
    @(posedge clk);
    acc = v && (m_busy == 0);
    ret = acc && (wd == 14'h0040 || wd == 14'h0060 || wd[13:8] == 6'b011000);
    m_unh = (acc && !ret && wd != 14'h0000) ? 1 : 0;
    if (ret) begin
      m_sp = (m_sp + 7) % 8;
      m_pc = m_stk[m_sp];
      if (wd == 14'h0060) m_gie = 1;
      if (wd[13:8] == 6'b011000) m_w = int'(wd[7:0]);
    end else if (p) begin
      m_stk[m_sp] = pa;
      m_sp = (m_sp + 1) % 8;
    end
    m_busy = ret ? 1 : 0;
    #1;
    compare_all(tag);
  endtask

  task automatic push(input string tag, input int a);
    step(tag, 1'b0, 14'h0, 1'b1, a);
  endtask

  task automatic ins(input string tag, input logic [13:0] wd);
    step(tag, 1'b1, wd, 1'b0, 0);
  endtask

  initial begin : watchdog
    #(5 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    compare_all("R1 after reset");

    // R8 pushes, R2 idle
    push("R8", 10'h101); push("R8", 10'h202); push("R8", 10'h303);
    ins("R2 idle", 14'h0000);
    ins("R2 idle", 14'h0000);
    // R3 plain return, then R6 word ignored while busy
    ins("R3 ret", 14'h0040);
    ins("R6 ignored reti", 14'h0060);
    // R4
    ins("R4 reti", 14'h0060);
    ins("R6 ignored other", 14'h1234);
    // R5
    ins("R5 retlw", 14'h18A5);
    ins("R6 ignored retlw", 14'h1811);
    // R7 near-miss opcodes
    ins("R7 other", 14'h1234);
    ins("R7 near ret", 14'h0041);
    ins("R7 near retlw", 14'h1900);
    ins("R7 near reti", 14'h0020);
    step("R6 invalid", 1'b0, 14'h0040, 1'b0, 0);
    // R10 push with return dropped
    push("R10", 10'h155);
    step("R10 ret+push", 1'b1, 14'h0040, 1'b1, 10'h2AA);
    ins("R2 idle", 14'h0000);
    push("R10", 10'h066);
    ins("R10 pop order", 14'h0040);
    ins("R2 idle", 14'h0000);
    // R5 table lookup with boundary literals
    for (int i = 0; i < 3; i++) push("R5", 10'h3F0 + i);
    ins("R5 k=00", 14'h1800); ins("R2", 14'h0000);
    ins("R5 k=FF", 14'h18FF); ins("R2", 14'h0000);
    ins("R5 k=7E", 14'h187E); ins("R2", 14'h0000);
    // R9 overflow and underflow wrap
    for (int i = 0; i < 9; i++) push("R9 push", 10'h040 + i * 3);
    for (int i = 0; i < 10; i++) begin
      ins("R9 pop", 14'h0040);
      ins("R6 busy idle", 14'h0000);
    end
    // R11 gie remains set across returns
    ins("R11 ret", 14'h0040); ins("R11", 14'h0000);
    ins("R11 retlw", 14'h1822); ins("R11", 14'h0000);
    // R1 reset again
    @(negedge clk); rst = 1'b1; instr_valid = 1'b0; push_req = 1'b0;
    @(posedge clk); #1;
    m_pc = 0; m_w = 0; m_gie = 0; m_busy = 0; m_unh = 0; m_sp = 0;
    compare_all("R1 re-reset");
    @(negedge clk); rst = 1'b0;
    push("R1 sp empty", 10'h0AB);
    ins("R1 sp empty pop", 14'h0040);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule